// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A synthesizable model of a 36-bit-wide pipelined synchronous SRAM. Reads, writes and deselect cycles can be issued on consecutive clocks in any mix, and the data bus never needs an idle cycle between directions. Each command owns one bus slot, two active edges after it is sampled. Read data is driven during that slot. Write data is presented during the same slot and is captured at the edge that closes it. A write and the read that follows it therefore never use the bus in the same cycle.

The storage is split into two banks chosen by the top address bit. Each bank is built from four 9-bit byte lanes, so the upper two lanes form one 18-bit half and the lower two lanes form the other. A load cycle can be followed by advance cycles that continue a four-beat burst. A static mode pin selects linear or interleaved beat order. A clock-enable pin freezes the whole pipeline. An output-enable pin gates only the bus drivers, and it acts without waiting for a clock.

The bidirectional bus is modelled as separate input, output and drive-enable ports. Memory depth is set by the address width parameter.

Top module: `zbt_sram`

## Requirements
- R1: After synchronous reset, dq_oe is low and dq_out is zero, and no command from before the reset produces a bus slot.
- R2: A load cycle (adv low, every cs_n bit low, we low) sampled at active edge E0 reads the addressed word. After the second later active edge, dq_out holds that word and dq_oe is high, provided oe_n is low.
- R3: A write command's data is taken from dq_in at the third active edge after the command. Byte lane l is dq bits [9l+8:9l], and it is stored only when byte_wr_n[l] is low at the command cycle.
- R4: Commands may follow each other on every active edge with no idle cycle. A read returns the effect of every earlier write, including writes whose data has not yet been stored. A write's bus slot leaves dq_oe low.
- R5: A load cycle with any cs_n bit high is a deselect. It accesses no word, its bus slot leaves dq_oe low, and dq_in during that slot is not stored.
- R6: While oe_n is high, dq_oe is low with no clock edge needed. Read data is still loaded into dq_out, and dq_oe rises as soon as oe_n falls.
- R7: With burst_ilv low, a cycle with adv high repeats the kind of the last load (read, write or deselect) and ignores we and cs_n. The k-th advance after a load uses the load address with its low two bits replaced by (base+k) mod 4.
- R8: With burst_ilv high, the k-th advance uses the low two address bits base XOR (k mod 4), and the upper bits stay unchanged.
- R9: During burst writes, byte_wr_n is sampled on every beat and selects the lanes written for that beat only.
- R10: An active edge with clk_en_n high changes nothing. dq_out and dq_oe hold their values, and neither the command pins nor dq_in have any effect.
- R11: Address bit ADDR_W-1 selects the bank. Two addresses that differ only in that bit hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the whole pipeline |
| adv | input | 1 | 1 = advance the burst, 0 = load a new command |
| we | input | 1 | Write (1) or read (0) on a load cycle |
| cs_n | input | NUM_CS | Active-low chip enables; all must be low to select |
| byte_wr_n | input | LANES | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address; the top bit selects the bank |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dq_in | input | LANE_W*LANES | Write data from the bus |
| dq_out | output | LANE_W*LANES | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with an 8-bit address, which gives two banks of 128 words. It keeps a full shadow copy of the array and can place aliasing addresses in both banks. Two chip enables allow a deselect to be raised by a single enable while the other stays active. The same command table runs once in each burst order. Because the table issues a write, a masked write and a read to one word on three consecutive edges, both forwarding paths (the stored-data path and the live dq_in path) are exercised in one read.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    SK_IDLE  = 2'd0,
    SK_READ  = 2'd1,
    SK_WRITE = 2'd2
  } slot_kind_e;

  // low address bits for a burst beat
  function automatic logic [BEAT_W-1:0] beat_offset(input logic [BEAT_W-1:0] base,
                                                    input logic [BEAT_W-1:0] beat,
                                                    input logic ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction
endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic              ilv,
  output slot_kind_e        kind,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LANES-1:0]  msk
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  slot_kind_e        last_q;

  always_comb begin
    msk = ~byte_wr_n;
    if (!adv) begin
      kind     = sel_ok ? (we ? SK_WRITE : SK_READ) : SK_IDLE;
      eff_addr = addr;
    end else begin
      kind     = last_q;
      eff_addr = {base_q[ADDR_W-1:BEAT_W], beat_offset(base_q[BEAT_W-1:0], beat_q, ilv)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      last_q <= SK_IDLE;
    end else if (ce) begin
      if (!adv) begin
        base_q <= addr;
        beat_q <= BEAT_W'(1);
        last_q <= kind;
      end else begin
        beat_q <= beat_q + BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/zbt_lane_ram.sv
module zbt_lane_ram #(
  parameter int AW = 7,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // read returns the old word when both ports hit one address
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int NUM_CS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clk_en_n,
  input  logic                      adv,
  input  logic                      we,
  input  logic [NUM_CS-1:0]         cs_n,
  input  logic [LANES-1:0]          byte_wr_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      burst_ilv,
  input  logic                      oe_n,
  input  logic [LANE_W*LANES-1:0]   dq_in,
  output logic [LANE_W*LANES-1:0]   dq_out,
  output logic                      dq_oe
);
  localparam int DW      = LANE_W * LANES;
  localparam int BANK_AW = ADDR_W - 1;
  localparam int BANKS   = 2;
  localparam int STAGES  = 3;

  logic ce;
  assign ce = ~clk_en_n;

  slot_kind_e        cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_msk;

  zbt_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .adv      (adv),
    .sel_ok   (&(~cs_n)),
    .we       (we),
    .addr     (addr),
    .byte_wr_n(byte_wr_n),
    .ilv      (burst_ilv),
    .kind     (cmd_kind),
    .eff_addr (cmd_addr),
    .msk      (cmd_msk)
  );

  // stage 0: memory read, stage 1: output, stage 2: write commit
  slot_kind_e        kind_q [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];
  logic [LANES-1:0]  msk_q  [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) kind_q[s] <= SK_IDLE;
    end else if (ce) begin
      kind_q[0] <= cmd_kind;
      for (int s = 1; s < STAGES; s++) kind_q[s] <= kind_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      addr_q[0] <= cmd_addr;
      msk_q[0]  <= cmd_msk;
      for (int s = 1; s < STAGES; s++) begin
        addr_q[s] <= addr_q[s-1];
        msk_q[s]  <= msk_q[s-1];
      end
    end
  end

  logic wr_go;
  assign wr_go = ce && (kind_q[STAGES-1] == SK_WRITE);

  logic [BANKS-1:0][DW-1:0] bank_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      zbt_lane_ram #(.AW(BANK_AW), .W(LANE_W)) u_ram (
        .clk    (clk),
        .rd_en  (ce),
        .wr_en  (wr_go && (addr_q[STAGES-1][ADDR_W-1] == 1'(b)) && msk_q[STAGES-1][l]),
        .wr_addr(addr_q[STAGES-1][BANK_AW-1:0]),
        .wr_data(dq_in[l*LANE_W +: LANE_W]),
        .rd_addr(addr_q[0][BANK_AW-1:0]),
        .rd_data(bank_q[b][l*LANE_W +: LANE_W])
      );
    end
  end

  // write committing while a read sits in stage 0
  logic              fwd_v;
  logic [DW-1:0]     fwd_d;
  logic [LANES-1:0]  fwd_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_v <= 1'b0;
    end else if (ce) begin
      fwd_v <= (kind_q[STAGES-1] == SK_WRITE) && (addr_q[STAGES-1] == addr_q[0]);
      fwd_d <= dq_in;
      fwd_m <= msk_q[STAGES-1];
    end
  end

  logic [DW-1:0] merged;
  logic          live_hit;

  always_comb begin
    merged   = bank_q[addr_q[1][ADDR_W-1]];
    live_hit = (kind_q[STAGES-1] == SK_WRITE) && (addr_q[STAGES-1] == addr_q[1]);
    for (int l = 0; l < LANES; l++) begin
      if (fwd_v && fwd_m[l])
        merged[l*LANE_W +: LANE_W] = fwd_d[l*LANE_W +: LANE_W];
      if (live_hit && msk_q[STAGES-1][l])
        merged[l*LANE_W +: LANE_W] = dq_in[l*LANE_W +: LANE_W];
    end
  end

  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out  <= '0;
      drive_q <= 1'b0;
    end else if (ce) begin
      drive_q <= (kind_q[1] == SK_READ);
      if (kind_q[1] == SK_READ) dq_out <= merged;
    end
  end

  assign dq_oe = drive_q & ~oe_n;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int NUM_CS = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clk_en_n,
  input logic                    adv,
  input logic                    we,
  input logic [NUM_CS-1:0]       cs_n,
  input logic                    oe_n,
  input logic [LANE_W*LANES-1:0] dq_out,
  input logic                    dq_oe
);
  logic sel_all, rd_ld, wr_ld, ds_ld;
  assign sel_all = &(~cs_n);
  assign rd_ld   = !adv && sel_all && !we;
  assign wr_ld   = !adv && sel_all && we;
  assign ds_ld   = !adv && !sel_all;

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dq_oe);

  a_r2_read_drives_slot: assert property (@(posedge clk) disable iff (rst)
    (rd_ld && !clk_en_n) ##1 !clk_en_n ##1 !clk_en_n |=> (dq_oe || oe_n));

  a_r4_write_slot_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_ld && !clk_en_n) ##1 !clk_en_n ##1 !clk_en_n |=> !dq_oe);

  a_r5_deselect_slot_quiet: assert property (@(posedge clk) disable iff (rst)
    (ds_ld && !clk_en_n) ##1 !clk_en_n ##1 !clk_en_n |=> !dq_oe);

  a_r10_stall_holds_data: assert property (@(posedge clk) disable iff (rst)
    (!rst && clk_en_n) |=> $stable(dq_out));
endmodule

bind zbt_sram zbt_sram_chk #(.LANE_W(LANE_W), .LANES(LANES), .NUM_CS(NUM_CS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clk_en_n(clk_en_n),
  .adv     (adv),
  .we      (we),
  .cs_n    (cs_n),
  .oe_n    (oe_n),
  .dq_out  (dq_out),
  .dq_oe   (dq_oe)
);

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;
  localparam int AW = 8, LW = 9, NL = 4, NCS = 2, DW = LW * NL;
  localparam logic [1:0] OP_DS = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_AD = 2'd3;
  localparam int NT = 28;
  // {op, addr, byte_wr_n}
  localparam logic [13:0] TBL [NT] = '{
    {OP_WR, 8'h10, 4'h0}, {OP_WR, 8'h11, 4'h0}, {OP_WR, 8'h12, 4'h0}, {OP_WR, 8'h13, 4'h0},
    {OP_WR, 8'h90, 4'h0},                         // R11 alias of 0x10 in other bank
    {OP_RD, 8'h10, 4'h0}, {OP_RD, 8'h90, 4'h0},   // R11 both banks independent
    {OP_WR, 8'h21, 4'h0}, {OP_WR, 8'h21, 4'hA},   // R3 lanes 0 and 2 only
    {OP_RD, 8'h21, 4'h0},                         // R4 forwarding from both paths
    {OP_DS, 8'h00, 4'h0},                         // R5 deselect
    {OP_RD, 8'h12, 4'h0}, {OP_WR, 8'h13, 4'h0}, {OP_RD, 8'h13, 4'h0},
    {OP_RD, 8'h11, 4'h0}, {OP_AD, 8'h00, 4'h0}, {OP_AD, 8'h00, 4'h0}, {OP_AD, 8'h00, 4'h0},
    {OP_WR, 8'h11, 4'h0}, {OP_AD, 8'h00, 4'h0},
    {OP_AD, 8'h00, 4'h3},                         // R9 beat writes lanes 2 and 3
    {OP_AD, 8'h00, 4'h0},
    {OP_RD, 8'h11, 4'h0}, {OP_AD, 8'h00, 4'h0}, {OP_AD, 8'h00, 4'h0}, {OP_AD, 8'h00, 4'h0},
    {OP_DS, 8'h00, 4'h0}, {OP_RD, 8'h90, 4'h0}
  };

  logic clk = 1'b0, rst = 1'b1, clk_en_n = 1'b0, adv = 1'b0, we = 1'b0;
  logic burst_ilv = 1'b0, oe_n = 1'b0;
  logic [NCS-1:0] cs_n = '1;
  logic [NL-1:0]  byte_wr_n = '1;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  dq_in = '0;
  logic [DW-1:0]  dq_out;
  logic           dq_oe;

  always #5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .NUM_CS(NCS)) u0 (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .adv(adv), .we(we), .cs_n(cs_n),
    .byte_wr_n(byte_wr_n), .addr(addr), .burst_ilv(burst_ilv), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int n_chk = 0, n_bad = 0, n = 0;
  logic [DW-1:0] ref_mem [1 << AW];
  int            kind_h [256];
  logic [DW-1:0] exp_h  [256];
  logic [DW-1:0] wd_h   [256];
  string         tag_h  [256];
  logic [AW-1:0] b_base = '0;
  int            b_beat = 0, b_kind = 0;
  bit            done = 0;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic step(logic [1:0] op, logic [AW-1:0] a, logic [NL-1:0] ben, int pass);
    logic [AW-1:0] ea;
    logic [1:0]    k, lo;
    logic [DW-1:0] wd;
    int            kd;
    string         tg;
    if (n >= 3) begin
      check({tag_h[n-3], " drive"}, DW'(dq_oe), DW'(kind_h[n-3] == 1 && !oe_n));
      if (kind_h[n-3] == 1) check({tag_h[n-3], " data"}, dq_out, exp_h[n-3]);
    end
    if (op == OP_AD) begin
      b_beat++;
      k  = 2'(b_beat);
      lo = burst_ilv ? (b_base[1:0] ^ k) : (b_base[1:0] + k);
      ea = {b_base[AW-1:2], lo};
      kd = b_kind;
      tg = burst_ilv ? "R8" : "R7";
    end else begin
      kd = (op == OP_DS) ? 0 : (op == OP_RD) ? 1 : 2;
      b_kind = kd; b_base = a; b_beat = 0; ea = a;
      tg = (op == OP_DS) ? "R5" : (op == OP_RD) ? "R2" : "R4";
    end
    wd = {4'(pass + 1), 32'(n * 32'h01010101 + 32'h5A5A0000)};
    if (kd == 2)
      for (int l = 0; l < NL; l++)
        if (!ben[l]) ref_mem[ea][l*LW +: LW] = wd[l*LW +: LW];
    kind_h[n] = kd;
    exp_h[n]  = (kd == 1) ? ref_mem[ea] : '0;
    wd_h[n]   = wd;
    tag_h[n]  = tg;
    clk_en_n  = 1'b0;
    adv       = (op == OP_AD);
    we        = (op == OP_AD) ? 1'b1 : (op == OP_WR);
    cs_n      = (op == OP_AD) ? 2'b11 : (op == OP_DS) ? 2'b10 : 2'b00;
    addr      = (op == OP_AD) ? 8'hEE : a;
    byte_wr_n = ben;
    dq_in     = (n >= 3 && kind_h[n-3] == 2) ? wd_h[n-3] : (36'hB_C3C3_0000 ^ DW'(n));
    @(posedge clk); @(negedge clk);
    n++;
  endtask

  task automatic stall_cycle();
    logic [DW-1:0] o;
    logic          e;
    o = dq_out; e = dq_oe;
    clk_en_n = 1'b1; adv = 1'b0; we = 1'b1; cs_n = '0; addr = 8'h10;
    byte_wr_n = '0; dq_in = 36'hF_0F0F_0F0F;
    @(posedge clk); @(negedge clk);
    check("R10 data hold", dq_out, o);
    check("R10 drive hold", DW'(dq_oe), DW'(e));
    clk_en_n = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 drive after reset", DW'(dq_oe), '0);
    check("R1 data after reset", dq_out, '0);
    for (int p = 0; p < 2; p++) begin
      burst_ilv = p[0];
      for (int i = 0; i < NT; i++) step(TBL[i][13:12], TBL[i][11:4], TBL[i][3:0], p);
    end
    // R10: stalls inside a forwarding window, stalled write to 0x10 must not land
    step(OP_WR, 8'h40, 4'h0, 2);
    stall_cycle();
    step(OP_RD, 8'h40, 4'h0, 2);
    stall_cycle();
    step(OP_RD, 8'h10, 4'h0, 2);
    stall_cycle();
    step(OP_DS, 8'h00, 4'h0, 2);
    step(OP_DS, 8'h00, 4'h0, 2);
    step(OP_DS, 8'h00, 4'h0, 2);
    // R6: output enable gating
    oe_n = 1'b1;
    step(OP_RD, 8'h21, 4'h0, 2);
    step(OP_DS, 8'h00, 4'h0, 2);
    step(OP_DS, 8'h00, 4'h0, 2);
    check("R6 drive off", DW'(dq_oe), '0);
    check("R6 data loaded", dq_out, exp_h[n-3]);
    oe_n = 1'b0;
    #1;
    check("R6 async drive on", DW'(dq_oe), DW'(1));
    for (int i = 0; i < 3; i++) step(OP_DS, 8'h00, 4'h0, 2);
    report();
  end
endmodule